// File: doc/BRIEF.md
# RDS Group Scheduler with Counted User-Group Insertion

This block decides which RDS group goes on air next and builds the four 16-bit information words (blocks A, B, C and D) for it. The bit serializer pulses `grp_req` when it needs a new group. One cycle later the block presents the four words, reports the kind of group it built, and pulses `grp_done`. Checkwords, differential coding and modulation are handled by later stages.

The basic rotation is a five-slot cycle. The first four slots are basic-tuning groups (type 0A), and each carries two programme-service characters and one pair of alternative-frequency codes. The fifth slot carries the first user group when that group is enabled. Otherwise it carries a radiotext group (type 2A) when radiotext is enabled. If neither is enabled, the fifth slot is one more 0A group. A host-loaded countdown takes priority over this rotation. While the countdown is nonzero, every request is answered with the second user group, the countdown drops by one per group, and the rotation and all segment pointers stay frozen. In both user groups, block B keeps its own group code and low bits, but its TP and PTY fields are overwritten with the configured values.

Top module: `rds_grp_sched`

## Requirements
- R1: A one-cycle `grp_req` produces a one-cycle `grp_done` on the next cycle. The words and `grp_kind` become valid at that point and hold until the next request.
- R2: Block A always equals `cfg_pi`, whatever the group kind.
- R3: `grp_kind` uses the codes 0 = 0A, 1 = 2A, 2 = first user group, 3 = second user group. With a zero countdown, slots 0 to 3 of each five-slot cycle are 0A. Slot 4 is the first user group if `usr1_en` is 1. Otherwise slot 4 is 2A if `rt_ctrl[0]` is 1, and 0A if it is not.
- R4: Block B of a 0A group is {4'h0, 1'b0, TP, PTY[4:0], TA_eff, MS, DI[3-s], s[1:0]}. The segment s advances 0,1,2,3,0 on each 0A group. Block D holds PS character 2s in its high byte and character 2s+1 in its low byte. Character i sits at `ps_name[8i+7:8i]`.
- R5: Block C of a 0A group holds codes 2p (high byte) and 2p+1 (low byte) of a code list. Code 0 is 0xE0 + `af_num`. Code k, for 1 ≤ k ≤ `af_num`, is `af_list[8(k-1)+7:8(k-1)]`. Every other code is the filler 0xCD. The pair index p advances on each 0A group and returns to 0 once code 2p+2 would exceed `af_num`.
- R6: Block B of a 2A group is {4'h2, 1'b0, TP, PTY, `rt_ctrl[1]`, seg[3:0]}. The segment cycles from 0 to RT_CHARS/4−1. Block C holds characters 4·seg and 4·seg+1, and block D holds characters 4·seg+2 and 4·seg+3, each with the lower index in the high byte.
- R7: In a user group, block B bits 10:5 are {TP, PTY} and its other bits come from the buffer's [47:32]. Blocks C and D copy the buffer's [31:16] and [15:0].
- R8: While `cnt_q` is nonzero, each request yields the second user group and lowers `cnt_q` by 1. The slot position and all segment and pair pointers do not change.
- R9: Once `cnt_q` reaches 0, the next request resumes the rotation at the slot where it paused.
- R10: `cnt_wr` loads `cnt_q` with `cnt_wdata`, limited to CNT_MAX. A host write wins over a decrement in the same cycle.
- R11: TA_eff is 1 when `cfg_ta` is 1, or when `ta_sw_n` is 0 while `cfg_tp` is 1. Otherwise TA_eff is 0.
- R12: After reset, `grp_done`, `cnt_q`, `grp_kind` and all four blocks are 0, and the next group is a 0A group with segment 0 and pair 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pi | input | 16 | Programme identification |
| cfg_pty | input | 5 | Programme type |
| cfg_tp | input | 1 | Traffic programme flag |
| cfg_ta | input | 1 | Traffic announcement register value |
| cfg_ms | input | 1 | Music/speech flag |
| cfg_di | input | 4 | Decoder identification bits |
| ta_sw_n | input | 1 | External traffic switch, active low |
| ps_name | input | 64 | Eight PS characters, character i at bits 8i+7:8i |
| rt_ctrl | input | 2 | Bit 0 enables radiotext, bit 1 is the A/B flag |
| rt_text | input | 8*RT_CHARS | Radiotext characters, character i at bits 8i+7:8i |
| usr1_en | input | 1 | First user group enable |
| usr1_words | input | 48 | First user group: B [47:32], C [31:16], D [15:0] |
| usr2_words | input | 48 | Second user group, same layout |
| af_num | input | 4 | Number of alternative frequencies |
| af_list | input | 8*AF_MAX | Frequency codes, entry j at bits 8j+7:8j |
| cnt_wr | input | 1 | Host write strobe for the countdown |
| cnt_wdata | input | $clog2(CNT_MAX+1) | Countdown value written by the host |
| cnt_q | output | $clog2(CNT_MAX+1) | Current countdown |
| grp_req | input | 1 | Request for the next group |
| grp_done | output | 1 | Words valid pulse |
| grp_kind | output | 2 | Kind of the group just built |
| blk_a | output | 16 | Block A word |
| blk_b | output | 16 | Block B word |
| blk_c | output | 16 | Block C word |
| blk_d | output | 16 | Block D word |

## Verification
The bench builds the block with RT_CHARS = 16, AF_MAX = 4 and CNT_MAX = 8. With only four radiotext segments, the wrap of the 2A address comes within about twenty requests. A four-entry frequency list lets the bench reach both the early pair wrap (three frequencies) and a pair padded with the 0xCD filler (four frequencies). With a 4-bit countdown field, the host can write values above the limit of 8, so the clamp can be exercised. The countdown tests also cover the case where a host write and a decrement land on the same edge.

// File: rtl/rds_sched_pkg.sv
package rds_sched_pkg;
   typedef enum logic [1:0] {
      GK_PS   = 2'd0,
      GK_RT   = 2'd1,
      GK_USR1 = 2'd2,
      GK_USR2 = 2'd3
   } grp_kind_e;

   localparam logic [3:0] TYPE_PS         = 4'd0;
   localparam logic [3:0] TYPE_RT         = 4'd2;
   localparam logic [7:0] AF_HDR_BASE     = 8'hE0;
   localparam logic [7:0] AF_FILL         = 8'hCD;
   localparam int         SLOTS_PER_CYCLE = 5;
endpackage

// File: rtl/rds_slot_seq.sv
module rds_slot_seq
   import rds_sched_pkg::*;
#(
   parameter int RT_SEGS  = 16,
   parameter int AF_PAIRS = 8,
   parameter int CNT_MAX  = 8,
   parameter int RSW      = (RT_SEGS > 1) ? $clog2(RT_SEGS) : 1,
   parameter int APW      = (AF_PAIRS > 1) ? $clog2(AF_PAIRS) : 1,
   parameter int CW       = $clog2(CNT_MAX + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           grp_req,
   input  logic           rt_en,
   input  logic           usr1_en,
   input  logic [3:0]     af_num,
   input  logic           cnt_wr,
   input  logic [CW-1:0]  cnt_wdata,
   output grp_kind_e      kind,
   output logic [1:0]     ps_seg,
   output logic [RSW-1:0] rt_seg,
   output logic [APW-1:0] af_pair,
   output logic [CW-1:0]  cnt_q
);
   localparam logic [2:0]     LAST_SLOT = 3'(SLOTS_PER_CYCLE - 1);
   localparam logic [RSW-1:0] RT_LAST   = RSW'(RT_SEGS - 1);
   localparam logic [APW-1:0] AF_LAST   = APW'(AF_PAIRS - 1);
   localparam logic [CW-1:0]  CNT_LIM   = CW'(CNT_MAX);

   logic [2:0]  slot;
   logic [31:0] af_next_idx;
   logic        af_wrap;

   always_comb begin
      if (cnt_q != '0)
         kind = GK_USR2;
      else if (slot == LAST_SLOT)
         kind = usr1_en ? GK_USR1 : (rt_en ? GK_RT : GK_PS);
      else
         kind = GK_PS;
   end

   assign af_next_idx = 32'(af_pair) * 32'd2 + 32'd2;
   assign af_wrap     = (af_next_idx > 32'(af_num)) || (af_pair == AF_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot    <= '0;
         ps_seg  <= '0;
         rt_seg  <= '0;
         af_pair <= '0;
      end else if (grp_req && kind != GK_USR2) begin
         slot <= (slot == LAST_SLOT) ? 3'd0 : slot + 3'd1;
         if (kind == GK_PS) begin
            ps_seg  <= ps_seg + 2'd1;
            af_pair <= af_wrap ? '0 : af_pair + APW'(1);
         end
         if (kind == GK_RT)
            rt_seg <= (rt_seg == RT_LAST) ? '0 : rt_seg + RSW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (cnt_wr)
         cnt_q <= (cnt_wdata > CNT_LIM) ? CNT_LIM : cnt_wdata;
      else if (grp_req && kind == GK_USR2)
         cnt_q <= cnt_q - CW'(1);
   end

   AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_LIM); // R10
   AST_CNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_req && kind == GK_USR2 && !cnt_wr) |=> cnt_q == $past(cnt_q) - CW'(1)); // R8
   AST_USR2_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_req && kind == GK_USR2) |=> (slot == $past(slot) && ps_seg == $past(ps_seg)
                                        && rt_seg == $past(rt_seg))); // R8
   AST_RT_SEG_LIM: assert property (@(posedge clk) disable iff (!rst_n)
      rt_seg <= RT_LAST); // R6
endmodule

// File: rtl/rds_word_build.sv
module rds_word_build
   import rds_sched_pkg::*;
#(
   parameter int RT_CHARS = 64,
   parameter int AF_MAX   = 15,
   parameter int AF_PAIRS = 8,
   parameter int RSW      = 4,
   parameter int APW      = 3
) (
   input  grp_kind_e             kind,
   input  logic [4:0]            pty,
   input  logic                  tp,
   input  logic                  ta_eff,
   input  logic                  ms,
   input  logic [3:0]            di,
   input  logic [63:0]           ps_name,
   input  logic                  rt_ab,
   input  logic [8*RT_CHARS-1:0] rt_text,
   input  logic [47:0]           usr1_words,
   input  logic [47:0]           usr2_words,
   input  logic [1:0]            ps_seg,
   input  logic [RSW-1:0]        rt_seg,
   input  logic [APW-1:0]        af_pair,
   input  logic [3:0]            af_num,
   input  logic [8*AF_MAX-1:0]   af_list,
   output logic [15:0]           word_b,
   output logic [15:0]           word_c,
   output logic [15:0]           word_d
);
   localparam int NCODES = 2 * AF_PAIRS;

   logic [7:0]  af_code [NCODES];
   logic [47:0] usr_sel;
   logic [31:0] rt_quad;
   logic [15:0] ps_pair;

   for (genvar k = 0; k < NCODES; k++) begin : g_af_code
      if (k == 0) begin : g_hdr
         assign af_code[k] = AF_HDR_BASE | {4'd0, af_num};
      end else if (k <= AF_MAX) begin : g_entry
         assign af_code[k] = (af_num >= 4'(k)) ? af_list[8*(k-1) +: 8] : AF_FILL;
      end else begin : g_pad
         assign af_code[k] = AF_FILL;
      end
   end

   assign usr_sel = (kind == GK_USR1) ? usr1_words : usr2_words;
   assign rt_quad = rt_text[32*rt_seg +: 32];
   assign ps_pair = ps_name[16*ps_seg +: 16];

   always_comb begin
      unique case (kind)
         GK_PS: begin
            word_b = {TYPE_PS, 1'b0, tp, pty, ta_eff, ms, di[2'd3 - ps_seg], ps_seg};
            word_c = {af_code[{af_pair, 1'b0}], af_code[{af_pair, 1'b1}]};
            word_d = {ps_pair[7:0], ps_pair[15:8]};
         end
         GK_RT: begin
            word_b = {TYPE_RT, 1'b0, tp, pty, rt_ab, 4'(rt_seg)};
            word_c = {rt_quad[7:0], rt_quad[15:8]};
            word_d = {rt_quad[23:16], rt_quad[31:24]};
         end
         default: begin
            word_b = {usr_sel[47:43], tp, pty, usr_sel[36:32]};
            word_c = usr_sel[31:16];
            word_d = usr_sel[15:0];
         end
      endcase
   end
endmodule

// File: rtl/rds_grp_sched.sv
module rds_grp_sched
   import rds_sched_pkg::*;
#(
   parameter int RT_CHARS = 64,
   parameter int AF_MAX   = 15,
   parameter int CNT_MAX  = 8,
   localparam int CW      = $clog2(CNT_MAX + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [15:0]           cfg_pi,
   input  logic [4:0]            cfg_pty,
   input  logic                  cfg_tp,
   input  logic                  cfg_ta,
   input  logic                  cfg_ms,
   input  logic [3:0]            cfg_di,
   input  logic                  ta_sw_n,
   input  logic [63:0]           ps_name,
   input  logic [1:0]            rt_ctrl,
   input  logic [8*RT_CHARS-1:0] rt_text,
   input  logic                  usr1_en,
   input  logic [47:0]           usr1_words,
   input  logic [47:0]           usr2_words,
   input  logic [3:0]            af_num,
   input  logic [8*AF_MAX-1:0]   af_list,
   input  logic                  cnt_wr,
   input  logic [CW-1:0]         cnt_wdata,
   output logic [CW-1:0]         cnt_q,
   input  logic                  grp_req,
   output logic                  grp_done,
   output logic [1:0]            grp_kind,
   output logic [15:0]           blk_a,
   output logic [15:0]           blk_b,
   output logic [15:0]           blk_c,
   output logic [15:0]           blk_d
);
   localparam int RT_SEGS  = RT_CHARS / 4;
   localparam int AF_PAIRS = (AF_MAX + 2) / 2;
   localparam int RSW      = (RT_SEGS > 1) ? $clog2(RT_SEGS) : 1;
   localparam int APW      = (AF_PAIRS > 1) ? $clog2(AF_PAIRS) : 1;

   if (RT_CHARS < 4 || RT_CHARS > 64 || (RT_CHARS % 4) != 0) begin : g_bad_rt
      $error("RT_CHARS must be a multiple of 4 between 4 and 64");
   end
   if (AF_MAX < 1 || AF_MAX > 15) begin : g_bad_af
      $error("AF_MAX must lie between 1 and 15");
   end
   if (CNT_MAX < 1) begin : g_bad_cnt
      $error("CNT_MAX must be at least 1");
   end

   grp_kind_e      kind;
   logic [1:0]     ps_seg;
   logic [RSW-1:0] rt_seg;
   logic [APW-1:0] af_pair;
   logic [15:0]    wb, wc, wd;
   logic           ta_eff;

   assign ta_eff = cfg_ta | (cfg_tp & ~ta_sw_n);

   rds_slot_seq #(
      .RT_SEGS(RT_SEGS), .AF_PAIRS(AF_PAIRS), .CNT_MAX(CNT_MAX),
      .RSW(RSW), .APW(APW), .CW(CW)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .grp_req(grp_req),
      .rt_en(rt_ctrl[0]), .usr1_en(usr1_en), .af_num(af_num),
      .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
      .kind(kind), .ps_seg(ps_seg), .rt_seg(rt_seg), .af_pair(af_pair), .cnt_q(cnt_q)
   );

   rds_word_build #(
      .RT_CHARS(RT_CHARS), .AF_MAX(AF_MAX), .AF_PAIRS(AF_PAIRS), .RSW(RSW), .APW(APW)
   ) u_build (
      .kind(kind), .pty(cfg_pty), .tp(cfg_tp), .ta_eff(ta_eff), .ms(cfg_ms), .di(cfg_di),
      .ps_name(ps_name), .rt_ab(rt_ctrl[1]), .rt_text(rt_text),
      .usr1_words(usr1_words), .usr2_words(usr2_words),
      .ps_seg(ps_seg), .rt_seg(rt_seg), .af_pair(af_pair),
      .af_num(af_num), .af_list(af_list),
      .word_b(wb), .word_c(wc), .word_d(wd)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grp_done <= 1'b0;
         grp_kind <= 2'd0;
         blk_a    <= '0;
         blk_b    <= '0;
         blk_c    <= '0;
         blk_d    <= '0;
      end else begin
         grp_done <= grp_req;
         if (grp_req) begin
            grp_kind <= kind;
            blk_a    <= cfg_pi;
            blk_b    <= wb;
            blk_c    <= wc;
            blk_d    <= wd;
         end
      end
   end

   AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      grp_req |=> grp_done); // R1
   AST_A_IS_PI: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_req && $stable(cfg_pi)) |=> blk_a == cfg_pi); // R2
   AST_USER_PTY: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_done && grp_kind[1]) |-> blk_b[10:5] == $past({cfg_tp, cfg_pty})); // R7
endmodule

// File: tb/rds_grp_sched_bench.sv
module rds_grp_sched_bench;
   localparam int CLK_PERIOD = 10;
   localparam int RT_CHARS   = 16;
   localparam int AF_MAX     = 4;
   localparam int CNT_MAX    = 8;
   localparam int CW         = $clog2(CNT_MAX + 1);
   localparam logic [4:0] PTY = 5'd10;
   localparam logic [3:0] DI  = 4'b1010;
   localparam logic [15:0] PI = 16'h30FF;

   // vector: {kind[1:0], seg[3:0], af_pair[1:0]}
   localparam logic [7:0] VEC [10] = '{
      {2'd0, 4'd0, 2'd0}, {2'd0, 4'd1, 2'd1}, {2'd0, 4'd2, 2'd0}, {2'd0, 4'd3, 2'd1},
      {2'd1, 4'd0, 2'd0},
      {2'd0, 4'd0, 2'd0}, {2'd0, 4'd1, 2'd1}, {2'd0, 4'd2, 2'd0}, {2'd0, 4'd3, 2'd1},
      {2'd1, 4'd1, 2'd0}
   };

   logic clk = 0, rst_n = 0;
   logic [4:0] cfg_pty = PTY;
   logic cfg_tp = 1, cfg_ta = 0, cfg_ms = 1, ta_sw_n = 1;
   logic [3:0] cfg_di = DI;
   logic [63:0] ps_name;
   logic [1:0] rt_ctrl = 2'b11;
   logic [8*RT_CHARS-1:0] rt_text;
   logic usr1_en = 0;
   logic [47:0] usr1_words = {16'h4FFF, 16'h1234, 16'h5678};
   logic [47:0] usr2_words = {16'hA800, 16'h9ABC, 16'hDEF0};
   logic [3:0] af_num = 4'd3;
   logic [8*AF_MAX-1:0] af_list;
   logic cnt_wr = 0;
   logic [CW-1:0] cnt_wdata = '0;
   logic [CW-1:0] cnt_q;
   logic grp_req = 0, grp_done;
   logic [1:0] grp_kind;
   logic [15:0] blk_a, blk_b, blk_c, blk_d;
   int n_chk = 0, n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rds_grp_sched #(.RT_CHARS(RT_CHARS), .AF_MAX(AF_MAX), .CNT_MAX(CNT_MAX)) u_rds_grp_sched (
      .clk(clk), .rst_n(rst_n), .cfg_pi(PI), .cfg_pty(cfg_pty), .cfg_tp(cfg_tp),
      .cfg_ta(cfg_ta), .cfg_ms(cfg_ms), .cfg_di(cfg_di), .ta_sw_n(ta_sw_n),
      .ps_name(ps_name), .rt_ctrl(rt_ctrl), .rt_text(rt_text), .usr1_en(usr1_en),
      .usr1_words(usr1_words), .usr2_words(usr2_words), .af_num(af_num), .af_list(af_list),
      .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cnt_q(cnt_q), .grp_req(grp_req),
      .grp_done(grp_done), .grp_kind(grp_kind),
      .blk_a(blk_a), .blk_b(blk_b), .blk_c(blk_c), .blk_d(blk_d)
   );

   task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
   endtask

   task automatic do_req();
      @(negedge clk) grp_req = 1;
      @(negedge clk) grp_req = 0;
   endtask

   task automatic host_write(logic [CW-1:0] v);
      @(negedge clk) begin cnt_wr = 1; cnt_wdata = v; end
      @(negedge clk) cnt_wr = 0;
   endtask

   function automatic logic [7:0] af_exp(int k, int num);
      if (k == 0) return 8'hE0 + 8'(num);
      if (k <= num) return 8'h11 * 8'(k);
      return 8'hCD;
   endfunction

   function automatic logic [15:0] b_ps(int s, logic ta);
      return {4'd0, 1'b0, cfg_tp, cfg_pty, ta, cfg_ms, cfg_di[3-s], 2'(s)};
   endfunction

   function automatic logic [15:0] b_rt(int s);
      return {4'd2, 1'b0, cfg_tp, cfg_pty, rt_ctrl[1], 4'(s)};
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      for (int i = 0; i < 8; i++) ps_name[8*i +: 8] = 8'h41 + 8'(i);
      for (int i = 0; i < RT_CHARS; i++) rt_text[8*i +: 8] = 8'h40 + 8'(i);
      for (int j = 0; j < AF_MAX; j++) af_list[8*j +: 8] = 8'h11 * 8'(j + 1);
      do_reset();

      // R12 reset state
      chk("R12 done", 16'(grp_done), 16'd0);
      chk("R12 cnt", 16'(cnt_q), 16'd0);
      chk("R12 blk_b", blk_b, 16'd0);
      chk("R12 blk_a", blk_a, 16'd0);

      // table walk: R3 R4 R5 R6 R2 R1
      for (int v = 0; v < 10; v++) begin
         automatic int k = int'(VEC[v][7:6]);
         automatic int s = int'(VEC[v][5:2]);
         automatic int p = int'(VEC[v][1:0]);
         do_req();
         chk("R1 done", 16'(grp_done), 16'd1);
         chk("R3 kind", 16'(grp_kind), 16'(k));
         chk("R2 blk_a", blk_a, PI);
         if (k == 0) begin
            chk("R4 blk_b", blk_b, b_ps(s, 1'b0));
            chk("R5 blk_c", blk_c, {af_exp(2*p, 3), af_exp(2*p+1, 3)});
            chk("R4 blk_d", blk_d, {ps_name[16*s +: 8], ps_name[16*s+8 +: 8]});
         end else begin
            chk("R6 blk_b", blk_b, b_rt(s));
            chk("R6 blk_c", blk_c, {8'h40 + 8'(4*s), 8'h41 + 8'(4*s)});
            chk("R6 blk_d", blk_d, {8'h42 + 8'(4*s), 8'h43 + 8'(4*s)});
         end
      end
      @(negedge clk);
      chk("R1 done pulse ends", 16'(grp_done), 16'd0);
      chk("R1 words held", blk_b, b_rt(1));

      // R6 radiotext segment wrap at RT_CHARS/4
      for (int g = 0; g < 15; g++) begin
         do_req();
         if (g % 5 == 4) chk("R6 rt seg wrap", blk_b, b_rt((2 + g / 5) % 4));
      end

      // R3 R7 first user group
      do_reset();
      usr1_en = 1;
      repeat (5) do_req();
      chk("R3 usr1 kind", 16'(grp_kind), 16'd2);
      chk("R7 usr1 blk_b", blk_b, {5'b01001, cfg_tp, cfg_pty, 5'b11111});
      chk("R7 usr1 blk_c", blk_c, 16'h1234);
      chk("R7 usr1 blk_d", blk_d, 16'h5678);
      chk("R2 usr1 blk_a", blk_a, PI);
      usr1_en = 0;

      // R3 fifth slot falls back to 0A
      do_reset();
      rt_ctrl = 2'b00;
      repeat (5) do_req();
      chk("R3 fallback kind", 16'(grp_kind), 16'd0);
      chk("R3 fallback blk_b", blk_b, b_ps(0, 1'b0));
      rt_ctrl = 2'b11;

      // R8 R9 countdown
      do_reset();
      repeat (2) do_req();
      host_write(CW'(2));
      chk("R10 cnt loaded", 16'(cnt_q), 16'd2);
      do_req();
      chk("R8 usr2 kind", 16'(grp_kind), 16'd3);
      chk("R8 cnt dec", 16'(cnt_q), 16'd1);
      chk("R7 usr2 blk_b", blk_b, {5'b10101, cfg_tp, cfg_pty, 5'b00000});
      chk("R7 usr2 blk_c", blk_c, 16'h9ABC);
      do_req();
      chk("R8 usr2 again", 16'(grp_kind), 16'd3);
      chk("R8 cnt zero", 16'(cnt_q), 16'd0);
      do_req();
      chk("R9 resume kind", 16'(grp_kind), 16'd0);
      chk("R9 resume seg", blk_b, b_ps(2, 1'b0));

      // R10 clamp and write priority
      host_write(CW'(12));
      chk("R10 clamp", 16'(cnt_q), 16'(CNT_MAX));
      host_write(CW'(3));
      @(negedge clk) begin grp_req = 1; cnt_wr = 1; cnt_wdata = CW'(5); end
      @(negedge clk) begin grp_req = 0; cnt_wr = 0; end
      chk("R10 same-cycle kind", 16'(grp_kind), 16'd3);
      chk("R10 write wins", 16'(cnt_q), 16'd5);
      host_write(CW'(0));

      // R11 traffic announcement
      do_reset();
      ta_sw_n = 0;
      do_req();
      chk("R11 switch with TP", 16'(blk_b[4]), 16'd1);
      cfg_tp = 0;
      do_req();
      chk("R11 switch without TP", 16'(blk_b[4]), 16'd0);
      cfg_ta = 1;
      do_req();
      chk("R11 register TA", 16'(blk_b[4]), 16'd1);
      cfg_ta = 0; cfg_tp = 1; ta_sw_n = 1;

      // R5 frequency list edges
      do_reset();
      rt_ctrl = 2'b00;
      af_num = 4'd0;
      repeat (2) begin
         do_req();
         chk("R5 empty list", blk_c, 16'hE0CD);
      end
      do_reset();
      af_num = 4'd4;
      for (int p = 0; p < 4; p++) begin
         do_req();
         chk("R5 full list", blk_c, {af_exp(2*(p%3), 4), af_exp(2*(p%3)+1, 4)});
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule